// File: doc/BRIEF.md
# Memory Write Protection Gate

This block sits in front of the program/erase engine of a nonvolatile memory. It watches the host's active-low write-enable and output-enable strobes and a supply-good flag from an external detector. A write cycle may start only when all of the following hold:

- the write-enable low pulse was wide enough;
- the supply has been good for a full power-on hold-off;
- output-enable stayed high for the whole pulse.

When a write may start, the block emits a one-cycle start pulse on the release edge of write-enable. It also reports whether writes are currently allowed, and it tells the read path to leave the data bus undriven while the supply is low.

Both strobes pass through a synchronizer before any measurement is made. The supply-good flag is taken as already synchronous to the clock.

The minimum strobe width and the hold-off length are cycle-count parameters. At a 200 MHz clock, 15 ns is 3 cycles and 5 ms is 1,000,000 cycles. A reduced hold-off may be passed in for short simulations.

Top module: `wr_protect_gate`

## Requirements
- R1: Each accepted write produces `wr_start` high for exactly one cycle. It is sampled high 3 clock edges after the first rising edge at which `we_n_raw` is seen high again: 2 synchronizer stages plus 1 output register.
- R2: A write-enable low period lasting fewer than `MIN_LOW_CYC` clock cycles produces no `wr_start`. A period of `MIN_LOW_CYC` cycles or more may produce one.
- R3: After `supply_ok` rises, `wr_allowed` stays low for `HOLD_CYC - 1` edges. It goes high after exactly `HOLD_CYC` consecutive edges with `supply_ok` high, provided output-enable is high.
- R4: Whenever `supply_ok` is low at a clock edge, the hold-off count returns to zero and the full hold-off restarts once the supply is good again.
- R5: Output-enable held low (`oe_n_raw` = 0) drives `wr_allowed` low within 2 cycles and blocks any write.
- R6: If the write inhibit is active in any cycle of the synchronized low period, or in the release cycle, no `wr_start` is produced for that pulse. The write inhibit is `wr_allowed` low: supply low, hold-off running, or output-enable low.
- R7: `rd_inhibit` equals the inverse of `supply_ok` in the same cycle, and `wr_allowed` is low whenever `rd_inhibit` is high.
- R8: While `we_n_raw` stays high, `wr_start` never asserts.
- R9: During and right after reset, `wr_start` and `wr_allowed` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n_raw | input | 1 | Host write-enable strobe, active low, unsynchronized |
| oe_n_raw | input | 1 | Host output-enable strobe, active low, unsynchronized |
| supply_ok | input | 1 | Supply-good flag from the external detector, synchronous to clk |
| wr_start | output | 1 | One-cycle pulse that starts a program/erase cycle |
| wr_allowed | output | 1 | High when a write could currently be accepted |
| rd_inhibit | output | 1 | High while the supply is not good; the data bus must stay undriven |

## Verification
The assertions assume that `supply_ok` changes only between clock edges, as a synchronous signal. They also assume that each strobe change holds long enough for the two-stage synchronizer to capture it.

The bench changes every input only on falling clock edges. It leaves at least eight idle cycles between write pulses, so that each release is measured on its own.

Random pulse widths, mid-pulse output-enable glitches and held output-enable phases are drawn only after the hold-off has completed. Early pulses and supply drops are directed cases with known timing.

// File: rtl/wr_protect_pkg.sv
package wr_protect_pkg;
  typedef struct packed {
    logic we_n;
    logic oe_n;
  } strobe_t;
  localparam int unsigned STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/wpg_sync.sv
module wpg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= INIT;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= INIT;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wpg_poweron_timer.sv
module wpg_poweron_timer #(
  parameter int unsigned HOLD_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt <= '0;
    else if (!supply_ok)      cnt <= '0;
    else if (cnt != LIMIT)    cnt <= cnt + 1'b1;

  assign ready = (cnt == LIMIT);

  AST_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (cnt == '0)); // R4
  AST_READY_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(supply_ok)); // R3
endmodule

// File: rtl/wpg_strobe_meter.sv
module wpg_strobe_meter #(
  parameter int unsigned MIN_LOW_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_s,
  input  logic allowed,
  output logic wr_start
);
  localparam int unsigned LW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LW-1:0] MINL = LW'(MIN_LOW_CYC);

  logic          we_d;
  logic [LW-1:0] low_cnt;
  logic          clean;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      we_d     <= 1'b1;
      low_cnt  <= '0;
      clean    <= 1'b0;
      wr_start <= 1'b0;
    end else begin
      we_d     <= we_s;
      wr_start <= 1'b0;
      if (!we_s) begin
        if (we_d) begin
          low_cnt <= LW'(1);
          clean   <= allowed;
        end else begin
          if (low_cnt != MINL) low_cnt <= low_cnt + 1'b1;
          clean <= clean & allowed;
        end
      end else if (!we_d) begin
        wr_start <= (low_cnt == MINL) && clean && allowed;
      end
    end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start); // R1
  AST_WIDTH_MET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> ($past(low_cnt) == MINL)); // R2
  AST_ALLOWED_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(allowed)); // R6
  AST_RELEASE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(we_s) && !$past(we_d)); // R8
endmodule

// File: rtl/wr_protect_gate.sv
module wr_protect_gate
  import wr_protect_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 3,
  parameter int unsigned HOLD_CYC    = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n_raw,
  input  logic oe_n_raw,
  input  logic supply_ok,
  output logic wr_start,
  output logic wr_allowed,
  output logic rd_inhibit
);
  strobe_t raw, synced;
  logic    pwr_ready;

  assign raw.we_n = we_n_raw;
  assign raw.oe_n = oe_n_raw;

  wpg_sync #(.WIDTH(STROBE_W), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  wpg_poweron_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ready(pwr_ready)
  );

  assign wr_allowed = pwr_ready & supply_ok & synced.oe_n;
  assign rd_inhibit = ~supply_ok;

  wpg_strobe_meter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .we_s(synced.we_n),
    .allowed(wr_allowed), .wr_start(wr_start)
  );

  AST_RDINH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inhibit |-> !wr_allowed); // R7
  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !synced.oe_n |-> !wr_allowed); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !wr_start && !wr_allowed); // R9
endmodule

// File: tb/sim_wr_protect_gate.sv
module sim_wr_protect_gate;
  localparam int MINW = 3;
  localparam int HOLD = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we_n_raw = 1'b1, oe_n_raw = 1'b1, supply_ok = 1'b0;
  logic wr_start, wr_allowed, rd_inhibit;
  int checks = 0, errors = 0, cyc = 0, pulses = 0, last_cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wr_protect_gate #(.MIN_LOW_CYC(MINW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .we_n_raw(we_n_raw), .oe_n_raw(oe_n_raw),
    .supply_ok(supply_ok), .wr_start(wr_start), .wr_allowed(wr_allowed),
    .rd_inhibit(rd_inhibit)
  );

  always begin
    @(posedge clk); #1;
    cyc++;
    if (wr_start) begin pulses++; last_cyc = cyc; end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(int len, bit clean, bit ready);
    return (ready && clean && len >= MINW) ? 1 : 0;
  endfunction

  // drive a low pulse of len cycles; optional oe glitch at index glitch (-1 none)
  task automatic pulse(int len, int glitch, output int got, output int ofs);
    int rel, start;
    start = pulses;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      we_n_raw = (i == len);
      oe_n_raw = (i == glitch) ? 1'b0 : 1'b1;
    end
    rel = cyc;
    @(negedge clk); oe_n_raw = 1'b1;
    repeat (8) @(negedge clk);
    got = pulses - start;
    ofs = last_cyc - rel;
  endtask

  task automatic power_up_wait();
    @(negedge clk); supply_ok = 1'b1;
    repeat (HOLD + 4) @(negedge clk);
  endtask

  initial begin
    int got, ofs;
    void'($urandom(32'h5eed_0042));
    #1;
    check("R9 reset wr_start", wr_start, 0);
    check("R9 reset wr_allowed", wr_allowed, 0);
    check("R7 rd_inhibit supply low", rd_inhibit, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after reset wr_allowed", wr_allowed, 0);

    // R3 hold-off edge timing
    @(negedge clk); supply_ok = 1'b1;
    #0.1 check("R7 rd_inhibit supply good", rd_inhibit, 0);
    repeat (HOLD - 1) @(posedge clk);
    #1 check("R3 still held at HOLD-1", wr_allowed, 0);
    @(posedge clk); #1 check("R3 allowed at HOLD", wr_allowed, 1);

    // R8 idle strobe
    got = pulses;
    repeat (50) @(negedge clk);
    check("R8 no start while we_n high", pulses - got, 0);

    // R1/R2 directed
    pulse(MINW, -1, got, ofs);
    check("R2 exact min width", got, 1);
    check("R1 start latency", ofs, 3);
    pulse(MINW - 1, -1, got, ofs);
    check("R2 short glitch rejected", got, 0);
    pulse(1, -1, got, ofs);
    check("R2 one-cycle glitch rejected", got, 0);

    // R5 oe held low
    @(negedge clk); oe_n_raw = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 wr_allowed with oe low", wr_allowed, 0);
    got = pulses;
    for (int i = 0; i < 6; i++) begin @(negedge clk); we_n_raw = (i == 5); oe_n_raw = 1'b0; end
    repeat (8) @(negedge clk);
    check("R5 no start with oe low", pulses - got, 0);
    oe_n_raw = 1'b1; repeat (4) @(negedge clk);

    // R6 oe glitch at release cycle
    pulse(5, 5, got, ofs);
    check("R6 inhibit at release", got, 0);

    // R4 supply drop restarts hold-off
    repeat (100) @(negedge clk);
    supply_ok = 1'b0;
    #0.1 check("R7 rd_inhibit follows drop", rd_inhibit, 1);
    check("R7 wr_allowed on drop", wr_allowed, 0);
    @(negedge clk); supply_ok = 1'b1;
    repeat (HOLD - 1) @(posedge clk);
    #1 check("R4 restart still held", wr_allowed, 0);
    @(posedge clk); #1 check("R4 restart allowed", wr_allowed, 1);

    // R3 early pulse during hold-off
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    pulse(5, -1, got, ofs);
    check("R3 pulse during hold-off", got, 0);
    repeat (HOLD) @(negedge clk);

    // R6 supply drop in mid pulse
    got = pulses;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); we_n_raw = (i == 5);
      supply_ok = (i != 2);
    end
    repeat (8) @(negedge clk);
    check("R6 supply drop mid pulse", pulses - got, 0);
    repeat (HOLD + 4) @(negedge clk);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int len, mode, g;
      len = 1 + int'($urandom % 6);
      mode = int'($urandom % 3);
      g = (mode == 1) ? int'($urandom % (len + 1)) : -1;
      if (mode == 2) begin
        @(negedge clk); oe_n_raw = 1'b0; repeat (3) @(negedge clk);
        got = pulses;
        for (int i = 0; i <= len; i++) begin @(negedge clk); we_n_raw = (i == len); oe_n_raw = 1'b0; end
        repeat (8) @(negedge clk);
        got = pulses - got;
        oe_n_raw = 1'b1; repeat (4) @(negedge clk);
      end else begin
        pulse(len, g, got, ofs);
      end
      check(mode == 0 ? "R2 random width" : "R6 random inhibit", got,
            exp_count(len, mode == 0, 1'b1));
      if (mode == 0 && got == 1) check("R1 random latency", ofs, 3);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule